// File: doc/BRIEF.md
# Saturating Signed Arithmetic Shifter

This block shifts a 32-bit two's-complement operand by a signed amount. The amount comes from the low bits of a second 32-bit word. A non-negative amount moves the operand toward the most significant bit and fills the vacated low bits with zeros. A negative amount moves it toward the least significant bit and copies the sign bit into the vacated high bits.

A left shift can push significant bits out of the top of the word. A mode input chooses what happens then:

- With saturation on, the result clamps to the largest positive or most negative 32-bit value, following the sign of the operand.
- With saturation off, the result keeps the low 32 bits of the shifted value, so it wraps.

An overflow flag reports the lost bits in both modes.

The shift logic is combinational. A parameter adds an output register that loads when a valid input is high. When the register is present, the result, the flag and a valid output all change together on one clock edge.

Top module: `sat_shifter`

## Requirements
- R1: The shift amount is bits [5:0] of `countWord`, read as a signed 6-bit value (-32 to +31). Bits [31:6] of `countWord` have no effect on the output.
- R2: A positive amount n shifts `operand` left by n bit positions and fills the low n bits with zeros.
- R3: A negative amount -m shifts `operand` right by m positions and fills the top m bits with copies of bit 31. An amount of -32 (field value 6'b100000) gives 32 copies of the sign bit.
- R4: An amount of zero returns `operand` unchanged, with `overflow` low.
- R5: A left shift by n sets `overflow` high when bits [31:31-n] of `operand` are not all equal. Otherwise `overflow` is low. This holds in both modes.
- R6: With `satEn` high, an overflowing left shift of an operand with bit 31 clear gives 0x7FFFFFFF.
- R7: With `satEn` high, an overflowing left shift of an operand with bit 31 set gives 0x80000000.
- R8: With `satEn` high, a left shift that does not overflow gives the exact shifted value.
- R9: With `satEn` low, a left shift gives the low 32 bits of the shifted value, even when it overflows.
- R10: Right shifts never set `overflow` and are never clamped, whatever the value of `satEn`.
- R11: With the output register present (the default), a cycle with `validIn` high loads `result` and `overflow` at the next rising edge and sets `validOut` high. A cycle with `validIn` low leaves `result` and `overflow` unchanged and drives `validOut` low.
- R12: `rstN` is an active-low synchronous reset. It clears `result`, `overflow` and `validOut` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Loads the output register with the current shift |
| operand | input | 32 | Signed value to shift |
| countWord | input | 32 | Word whose bits [5:0] give the signed shift amount |
| satEn | input | 1 | 1 = clamp on left-shift overflow, 0 = wrap |
| validOut | output | 1 | High for one cycle after each loaded shift |
| result | output | 32 | Shifted, clamped or wrapped value |
| overflow | output | 1 | A left shift lost significant bits |

## Verification
The bench drives count words whose upper bits are set, including one where the low six bits are zero. A design that decoded too wide a field would shift by a large amount or in the wrong direction.

It checks the edges of the overflow test:
- 0xC0000000 and 0xFFFFFFFF shifted left by 1 and by 31 must not flag. A detector that looks at one bit too many would raise a false overflow here.
- 0x40000000 and 0x00000001 must flag and clamp positive. A detector that looks at one bit too few would miss these and return wrapped values.

It also checks these cases:
- An amount of -32 must give all sign bits; a shifter built only to 31 would leak operand bits.
- A right shift in saturating mode must stay exact; clamping it would break this.
- A wrapped left shift must keep its low bits.
- An idle cycle must leave the last result in place.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(DATA_W) + 1;

  typedef struct packed {
    logic             goLeft;
    logic [CNT_W-1:0] amount;
    logic             satOn;
    logic             load;
  } shift_ctrl_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
(
  input  logic [DATA_W-1:0] countWord,
  input  logic              satEn,
  input  logic              validIn,
  output shift_ctrl_t       ctrl
);
  logic [CNT_W-1:0] cntField;
  logic             isNeg;

  // R1: only the low CNT_W bits carry the signed amount
  assign cntField = countWord[CNT_W-1:0];
  assign isNeg    = cntField[CNT_W-1];

  always_comb begin
    ctrl.goLeft = !isNeg;
    ctrl.amount = isNeg ? (~cntField + 1'b1) : cntField;
    ctrl.satOn  = satEn;
    ctrl.load   = validIn;
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  shift_ctrl_t       ctrl,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              overflow,
  output logic              validOut
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MAX_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]   leftVal;
  logic [2*DATA_W-1:0] extOp;
  logic [2*DATA_W-1:0] rightFull;
  logic [DATA_W-1:0]   rightVal;
  logic [DATA_W-1:0]   backVal;
  logic                ovfComb;
  logic [DATA_W-1:0]   resComb;

  assign leftVal   = operand << ctrl.amount;
  assign extOp     = {{DATA_W{operand[DATA_W-1]}}, operand};
  assign rightFull = extOp >> ctrl.amount;
  assign rightVal  = rightFull[DATA_W-1:0];
  // Undo the left shift arithmetically; any mismatch means bits were lost.
  assign backVal   = DATA_W'($signed(leftVal) >>> ctrl.amount);
  assign ovfComb   = ctrl.goLeft && (backVal != operand);

  always_comb begin
    if (!ctrl.goLeft)
      resComb = rightVal;
    else if (ovfComb && ctrl.satOn)
      resComb = operand[DATA_W-1] ? MAX_NEG : MAX_POS;
    else
      resComb = leftVal;
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          result   <= '0;
          overflow <= 1'b0;
          validOut <= 1'b0;
        end else begin
          validOut <= ctrl.load;
          if (ctrl.load) begin
            result   <= resComb;
            overflow <= ovfComb;
          end
        end
      end

      p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
        !ctrl.load |=> ($stable(result) && $stable(overflow) && !validOut));
      p_load_r11: assert property (@(posedge clk) disable iff (!rstN)
        ctrl.load |=> validOut);
      p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.load && !ctrl.goLeft) |=> !overflow);
      p_zero_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.load && ctrl.goLeft && ctrl.amount == '0) |=>
          (result == $past(operand) && !overflow));
      p_clamp_r6_r7: assert property (@(posedge clk) disable iff (!rstN)
        (ctrl.load && ctrl.satOn && ovfComb) |=>
          (result == ($past(operand[DATA_W-1]) ? MAX_NEG : MAX_POS)));
    end else begin : g_comb
      assign result   = resComb;
      assign overflow = ovfComb;
      assign validOut = ctrl.load;
    end
  endgenerate
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
  import shifter_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] countWord,
  input  logic              satEn,
  output logic              validOut,
  output logic [DATA_W-1:0] result,
  output logic              overflow
);
  shift_ctrl_t ctrl;

  shift_ctrl u_ctrl (
    .countWord (countWord),
    .satEn     (satEn),
    .validIn   (validIn),
    .ctrl      (ctrl)
  );

  shift_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .operand  (operand),
    .result   (result),
    .overflow (overflow),
    .validOut (validOut)
  );
endmodule

// File: tb/tb_sat_shifter.sv
module tb_sat_shifter;
  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn;
  logic [31:0] operand;
  logic [31:0] countWord;
  logic        satEn;
  logic        validOut;
  logic [31:0] result;
  logic        overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sat_shifter dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .operand(operand),
    .countWord(countWord), .satEn(satEn), .validOut(validOut),
    .result(result), .overflow(overflow)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runShift(string req, logic [31:0] op, logic [31:0] cnt,
                          logic sat, logic [31:0] expRes, logic expOvf);
    @(negedge clk);
    operand = op; countWord = cnt; satEn = sat; validIn = 1'b1;
    @(posedge clk); #1;
    check(req, result, expRes);
    check(req, {31'd0, overflow}, {31'd0, expOvf});
    check(req, {31'd0, validOut}, 32'd1);
    @(negedge clk);
    validIn = 1'b0;
  endtask

  task automatic testReset();
    check("R12", result, 32'h0);
    check("R12", {31'd0, overflow}, 32'd0);
    check("R12", {31'd0, validOut}, 32'd0);
  endtask

  task automatic testLeft();
    runShift("R2", 32'h01230001, 32'h00000001, 1'b1, 32'h02460002, 1'b0);
    runShift("R8", 32'h01230002, 32'h00000005, 1'b1, 32'h24600040, 1'b0);
    runShift("R8", 32'h0000000E, 32'h0000000E, 1'b1, 32'h00038000, 1'b0);
  endtask

  task automatic testSaturate();
    runShift("R6", 32'h12345678, 32'h00000005, 1'b1, 32'h7FFFFFFF, 1'b1);
    runShift("R6", 32'h00000001, 32'h0000001F, 1'b1, 32'h7FFFFFFF, 1'b1);
    runShift("R7", 32'h82345678, 32'h00000001, 1'b1, 32'h80000000, 1'b1);
  endtask

  task automatic testOverflowEdges();
    runShift("R5", 32'h40000000, 32'h00000001, 1'b1, 32'h7FFFFFFF, 1'b1);
    runShift("R5", 32'hC0000000, 32'h00000001, 1'b1, 32'h80000000, 1'b0);
    runShift("R5", 32'hFFFFFFFF, 32'h0000001F, 1'b1, 32'h80000000, 1'b0);
  endtask

  task automatic testWrap();
    runShift("R9", 32'h12345678, 32'h00000005, 1'b0, 32'h468ACF00, 1'b1);
    runShift("R9", 32'h82345678, 32'h00000001, 1'b0, 32'h0468ACF0, 1'b1);
  endtask

  task automatic testRight();
    runShift("R3", 32'h82345678, 32'h0000FFFA, 1'b1, 32'hFE08D159, 1'b0);
    runShift("R3", 32'hE89AFFF2, 32'hE89AFFF2, 1'b1, 32'hFFFFA26B, 1'b0);
    runShift("R3", 32'h4567FFFF, 32'h0000FFFF, 1'b0, 32'h22B3FFFF, 1'b0);
    runShift("R3", 32'h80000001, 32'h00000020, 1'b1, 32'hFFFFFFFF, 1'b0);
    runShift("R3", 32'h7FFFFFFF, 32'h00000020, 1'b0, 32'h00000000, 1'b0);
    runShift("R10", 32'h01230002, 32'h0000FFF1, 1'b1, 32'h00000246, 1'b0);
  endtask

  task automatic testFieldAndZero();
    runShift("R1", 32'h01230001, 32'hABCD0001, 1'b1, 32'h02460002, 1'b0);
    runShift("R1", 32'h01230002, 32'h0000FFC5, 1'b1, 32'h24600040, 1'b0);
    runShift("R1", 32'h87654321, 32'hFFFFFFC0, 1'b1, 32'h87654321, 1'b0);
    runShift("R4", 32'h87654321, 32'h00000000, 1'b0, 32'h87654321, 1'b0);
  endtask

  task automatic testHold();
    runShift("R11", 32'h12345678, 32'h00000005, 1'b1, 32'h7FFFFFFF, 1'b1);
    @(negedge clk);
    operand = 32'h00000001; countWord = 32'h00000001; satEn = 1'b0;
    validIn = 1'b0;
    @(posedge clk); #1;
    check("R11", result, 32'h7FFFFFFF);
    check("R11", {31'd0, overflow}, 32'd1);
    check("R11", {31'd0, validOut}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; validIn = 1'b0; operand = '0; countWord = '0; satEn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testLeft();
    testSaturate();
    testOverflowEdges();
    testWrap();
    testRight();
    testFieldAndZero();
    testHold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule